// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block serves one processor target of an interrupt distributor. It looks at every interrupt source and picks the most urgent one that is both enabled and pending. It then reports that source's ID to the processor interface and decides whether the processor's request line should be raised. Each source carries an 8-bit priority, and a numerically smaller value is more urgent. The arbiter walks the sources one per clock, so its cost grows with cycles rather than with comparator area.

Two thresholds follow the search. The processor's priority mask decides whether the winner is reported at all. The priority of the interrupt the processor is running now decides whether the reported winner may also raise the request line. That running priority is 9 bits wide: the value 0x100 means nothing is running. The distributor enable and the processor-interface enable can each force the result to "nothing pending".

The owner of the inputs pulses `start` after changing any of them. The block raises `busy` for the scan and `done` for one cycle once the new result is on the outputs. The source count is a parameter; it must be a multiple of 32 and no more than 1020.

Top module: `pend_prio_arbiter`

## Requirements
- R1: After reset, `hp_id` is 1023, and `irq_req`, `busy` and `done` are all 0.
- R2: Source i is a candidate only when `irq_enable[i]` and `irq_pending[i]` are both 1. Its priority is `irq_prio[8*i+7:8*i]`. The candidate with the smallest priority value wins, and `hp_id` reports its index i.
- R3: When two or more candidates share the smallest priority value, the one with the lowest index wins.
- R4: When no source is a candidate, `hp_id` is 1023 and `irq_req` is 0.
- R5: When `dist_en` or `cpu_en` is 0 at the end of a scan, `hp_id` is 1023 and `irq_req` is 0, whatever the candidates are.
- R6: The winner is reported only if its priority is strictly less than `prio_mask`. Otherwise `hp_id` is 1023 and `irq_req` is 0.
- R7: `irq_req` is 1 only when a winner is reported and its priority is strictly less than `run_prio`. A reported winner whose priority is equal to or greater than `run_prio` leaves `irq_req` at 0 but still appears on `hp_id`.
- R8: A `run_prio` of 0x100 (idle) lets any reported winner raise `irq_req`, including one with priority 0xFE under a mask of 0xFF.
- R9: `start` is taken only while `busy` is 0. `busy` rises on the next clock and stays high for NUM_IRQ cycles. `done` is a single-cycle pulse that carries the new result. `hp_id` and `irq_req` keep their previous values while `busy` is high. A `start` that arrives during a scan has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new scan (taken when idle) |
| dist_en | input | 1 | Distributor-wide enable |
| cpu_en | input | 1 | Enable of this processor's interface |
| irq_enable | input | NUM_IRQ | Per-source enable bits |
| irq_pending | input | NUM_IRQ | Per-source pending bits |
| irq_prio | input | 8*NUM_IRQ | Per-source priorities, source i in bits 8i+7..8i |
| prio_mask | input | 8 | Priority mask; winner must be strictly below it |
| run_prio | input | 9 | Running priority; 0x100 means idle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle strobe: result updated |
| hp_id | output | 10 | Highest pending ID, 1023 when none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is the boundary on each threshold. A winner whose priority equals the mask, or equals the running priority, has to flip the outcome, while one step below it has no effect on the other output. The stimulus therefore sets up pairs of otherwise identical scans that differ by one in a single threshold. Ties are placed at widely separated indices, and a winner is placed at the last index, so that the final scan cycle is exercised. A second `start` is injected in the middle of a scan. The bench then confirms that the scan length and the held outputs do not change.

// File: rtl/pprio_pkg.sv
package pprio_pkg;

    localparam int PRIO_W = 8;
    localparam int RANK_W = PRIO_W + 1;
    localparam int ID_W   = 10;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam irq_id_t SPURIOUS_ID = irq_id_t'(1023);
    localparam rank_t   RANK_NONE   = rank_t'(9'h100);

    typedef struct packed {
        irq_id_t id;
        rank_t   rank;
    } best_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    function automatic best_t no_winner();
        best_t b;
        b.id   = SPURIOUS_ID;
        b.rank = RANK_NONE;
        return b;
    endfunction

    // strictly better only: equal ranks keep the earlier (lower) index
    function automatic logic beats(rank_t cand, rank_t cur);
        return cand < cur;
    endfunction

    function automatic rank_t widen(prio_t p);
        return {1'b0, p};
    endfunction

endpackage

// File: rtl/pprio_scan_ctrl.sv
module pprio_scan_ctrl
    import pprio_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             clr,
    output logic             step,
    output logic             last,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_IRQ - 1);

    scan_st_e st_q;

    assign busy = (st_q == ST_SCAN);
    assign clr  = start && (st_q == ST_IDLE);
    assign step = busy;
    assign last = busy && (idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            idx  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q <= ST_SCAN;
                        idx  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (idx == IDX_LAST) begin
                        st_q <= ST_IDLE;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    accepted_start_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (busy && idx == '0));

    // R9
    scan_ends_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

endmodule

// File: rtl/pprio_best_track.sv
module pprio_best_track
    import pprio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    step,
    input  logic    cand_ok,
    input  rank_t   cand_rank,
    input  irq_id_t cand_id,
    output best_t   best_nxt,
    output best_t   best_q
);

    always_comb begin
        best_nxt = best_q;
        if (cand_ok && beats(cand_rank, best_q.rank)) begin
            best_nxt.id   = cand_id;
            best_nxt.rank = cand_rank;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_q <= no_winner();
        end else if (step) begin
            best_q <= best_nxt;
        end
    end

    // R2
    rank_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (best_q.rank <= $past(best_q.rank)));

    // R4
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (best_q.id == SPURIOUS_ID && best_q.rank == RANK_NONE));

endmodule

// File: rtl/pprio_publish.sv
module pprio_publish
    import pprio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fin,
    input  logic    dist_en,
    input  logic    cpu_en,
    input  prio_t   prio_mask,
    input  rank_t   run_prio,
    input  best_t   final_best,
    output irq_id_t hp_id,
    output logic    irq_req,
    output logic    done
);

    irq_id_t id_d;
    logic    req_d;
    logic    gate_ok;
    logic    unmasked;

    assign gate_ok  = dist_en && cpu_en;
    assign unmasked = final_best.rank < widen(prio_mask);

    always_comb begin
        id_d  = SPURIOUS_ID;
        req_d = 1'b0;
        if (gate_ok && unmasked) begin
            id_d  = final_best.id;
            req_d = final_best.rank < run_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_id   <= SPURIOUS_ID;
            irq_req <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                hp_id   <= id_d;
                irq_req <= req_d;
            end
        end
    end

    // R7
    req_needs_id_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (hp_id != SPURIOUS_ID));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fin |=> ($stable(hp_id) && $stable(irq_req)));

    // R5
    gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && !gate_ok) |=> (hp_id == SPURIOUS_ID && !irq_req));

endmodule

// File: rtl/pend_prio_arbiter.sv
module pend_prio_arbiter
    import pprio_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      dist_en,
    input  logic                      cpu_en,
    input  logic [NUM_IRQ-1:0]        irq_enable,
    input  logic [NUM_IRQ-1:0]        irq_pending,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         prio_mask,
    input  logic [RANK_W-1:0]         run_prio,
    output logic                      busy,
    output logic                      done,
    output logic [ID_W-1:0]           hp_id,
    output logic                      irq_req
);

    logic             clr;
    logic             step;
    logic             last;
    logic [IDX_W-1:0] idx;

    prio_t            prio_arr [NUM_IRQ];
    logic             cand_ok;
    rank_t            cand_rank;
    irq_id_t          cand_id;
    best_t            best_nxt;
    best_t            best_q;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign prio_arr[g] = irq_prio[g*PRIO_W +: PRIO_W];
    end

    assign cand_ok   = irq_enable[idx] && irq_pending[idx];
    assign cand_rank = widen(prio_arr[idx]);
    assign cand_id   = irq_id_t'(idx);

    pprio_scan_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .clr   (clr),
        .step  (step),
        .last  (last),
        .idx   (idx)
    );

    pprio_best_track u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .step      (step),
        .cand_ok   (cand_ok),
        .cand_rank (cand_rank),
        .cand_id   (cand_id),
        .best_nxt  (best_nxt),
        .best_q    (best_q)
    );

    pprio_publish u_pub (
        .clk        (clk),
        .rst        (rst),
        .fin        (last),
        .dist_en    (dist_en),
        .cpu_en     (cpu_en),
        .prio_mask  (prio_mask),
        .run_prio   (run_prio),
        .final_best (best_nxt),
        .hp_id      (hp_id),
        .irq_req    (irq_req),
        .done       (done)
    );

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(busy));

endmodule

// File: tb/pend_prio_arbiter_bench.sv
module pend_prio_arbiter_bench;

    localparam int N = 64;

    typedef struct {
        logic [9:0] id;
        logic       req;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic dist_en = 1'b1;
    logic cpu_en = 1'b1;
    logic [N-1:0] en_v = '0;
    logic [N-1:0] pd_v = '0;
    logic [7:0]   pr_a [N];
    logic [N*8-1:0] pr_v;
    logic [7:0] mask = 8'hFF;
    logic [8:0] runp = 9'h100;
    logic busy, done, irq_req;
    logic [9:0] hp_id;

    int tests = 0;
    int fails = 0;
    exp_t sb[$];
    logic [9:0] last_id = 10'd1023;
    logic       last_req = 1'b0;

    always #4 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) pr_v[i*8 +: 8] = pr_a[i];

    pend_prio_arbiter #(.NUM_IRQ(N)) u_pend_prio_arbiter (
        .clk(clk), .rst(rst), .start(start), .dist_en(dist_en), .cpu_en(cpu_en),
        .irq_enable(en_v), .irq_pending(pd_v), .irq_prio(pr_v),
        .prio_mask(mask), .run_prio(runp), .busy(busy), .done(done),
        .hp_id(hp_id), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // reference from the requirements
    function automatic exp_t predict(input string tag);
        exp_t e;
        int best = 256;
        int bid = 1023;
        for (int i = 0; i < N; i++)
            if (en_v[i] && pd_v[i] && int'(pr_a[i]) < best) begin
                best = int'(pr_a[i]);
                bid  = i;
            end
        e.id = 10'd1023; e.req = 1'b0; e.tag = tag;
        if (dist_en && cpu_en && best < int'(mask)) begin
            e.id  = 10'(bid);
            e.req = best < int'(runp);
        end
        return e;
    endfunction

    task automatic clear_all();
        en_v = '0; pd_v = '0;
        for (int i = 0; i < N; i++) pr_a[i] = 8'hFF;
        dist_en = 1'b1; cpu_en = 1'b1; mask = 8'hFF; runp = 9'h100;
    endtask

    task automatic put(input int i, input logic [7:0] p, input bit e, input bit pd);
        pr_a[i] = p; en_v[i] = e; pd_v[i] = pd;
    endtask

    // driver: predicts, queues, runs one scan, checks its length
    task automatic run_case(input string tag, input int want_id, input bit want_req,
                            input bit poke);
        exp_t e;
        int cyc;
        e = predict(tag);
        check(e.id == 10'(want_id) && e.req == want_req, tag, "model sanity",
              int'(e.id), want_id);
        sb.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 10) start = 1'b1;
            if (poke && cyc == 11) start = 1'b0;
        end
        check(cyc == N + 1, "R9", "scan length", cyc, N + 1);
    endtask

    // monitor: compares results and the hold behaviour
    always @(negedge clk) begin
        if (!rst && busy) begin
            if (hp_id != last_id || irq_req != last_req) begin
                fails++;
                $display("FAIL R9 hold during scan: actual %0d expected %0d",
                         hp_id, last_id);
            end
        end
        if (!rst && done) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                check(hp_id == e.id, e.tag, "hp_id", int'(hp_id), int'(e.id));
                check(irq_req == e.req, e.tag, "irq_req", int'(irq_req), int'(e.req));
            end
            last_id  = hp_id;
            last_req = irq_req;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(hp_id == 10'd1023, "R1", "hp_id", int'(hp_id), 1023);
        check(!irq_req && !busy && !done, "R1", "req/busy/done",
              int'({irq_req, busy, done}), 0);

        // R2 single source, R8 idle running priority
        put(5, 8'h40, 1, 1);
        run_case("R2", 5, 1, 0);
        // R2 smallest value wins, disabled lower one ignored
        put(40, 8'h10, 1, 1); put(20, 8'h05, 0, 1); put(30, 8'h01, 1, 0);
        run_case("R2", 40, 1, 0);
        // R2 winner at last index
        put(63, 8'h02, 1, 1);
        run_case("R2", 63, 1, 0);
        // R3 tie at 10 and 50
        clear_all(); put(50, 8'h20, 1, 1); put(10, 8'h20, 1, 1); put(60, 8'h30, 1, 1);
        run_case("R3", 10, 1, 0);
        // R4 nothing qualifies
        clear_all(); put(7, 8'h00, 1, 0); put(8, 8'h00, 0, 1);
        run_case("R4", 1023, 0, 0);
        // R5 distributor off, then interface off
        clear_all(); put(3, 8'h10, 1, 1);
        dist_en = 1'b0;
        run_case("R5", 1023, 0, 0);
        dist_en = 1'b1; cpu_en = 1'b0;
        run_case("R5", 1023, 0, 0);
        cpu_en = 1'b1;
        // R6 mask boundary
        mask = 8'h10;
        run_case("R6", 1023, 0, 0);
        mask = 8'h11;
        run_case("R6", 3, 1, 0);
        // R7 running priority boundary
        mask = 8'hFF; runp = 9'h010;
        run_case("R7", 3, 0, 0);
        runp = 9'h011;
        run_case("R7", 3, 1, 0);
        // R8 idle running priority with 0xFE winner
        clear_all(); put(33, 8'hFE, 1, 1);
        run_case("R8", 33, 1, 0);
        // R9 start during scan ignored
        clear_all(); put(12, 8'h44, 1, 1);
        run_case("R9", 12, 1, 1);
        repeat (3) @(negedge clk);
        check(!busy && !done && sb.size() == 0, "R9", "no second scan",
              int'({busy, done}), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule